// File: doc/BRIEF.md
# DisplayPort Lane and Rate Selector

This block picks the main-link configuration for a display mode. A controller gives it the mode's pixel clock in kHz, the sink's maximum link rate code and the sink's lane-count capability byte, then pulses `start_i`. The block walks an interleaved bandwidth table one entry per clock. The table is built from a per-lane base bandwidth at each of the two link rates, and each step of lanes appears once at each rate. The search stops at the first entry whose bandwidth is strictly above the requested clock, subject to the sink's limits.

The result is a lane count (1, 2 or 4), a link clock (162000 or 270000 kHz) and a mode-valid flag. The outputs are registered and are announced by a one-cycle `done_o` pulse. When no allowed entry fits, the block reports zero lanes, zero link clock and an invalid mode, so the caller can treat the mode's clock as too high.

The controller has two states. ST_IDLE waits for a start and latches the inputs on that start (transition IDLE->SCAN). ST_SCAN examines one table index per cycle. From ST_SCAN the block either advances to the next index (SCAN->SCAN), or returns to ST_IDLE on a hit or on a miss (SCAN->IDLE) and publishes the result.

Top module: `dp_link_select`

## Requirements
- R1: After reset, `done_o` is 0, `mode_ok_o` is 0, and both `lanes_o` and `link_khz_o` are 0.
- R2: The table entries for indices 0..5 are 54000, 90000, 108000, 180000, 216000 and 360000 kHz. The search picks the lowest allowed index whose entry is strictly greater than the mode clock. Indices 0 and 1 give 1 lane, indices 2 and 3 give 2 lanes, and indices 4 and 5 give 4 lanes.
- R3: Only the rate code 8'h0A enables the high rate. With any other code, odd indices are skipped and a chosen configuration always reports 162000.
- R4: With the high rate enabled, an odd chosen index reports 270000 and an even chosen index reports 162000.
- R5: The sink lane count is the lane byte ANDed with 8'h1F. A value of 1 makes any index above 1 a miss. A value of 2 makes any index above 3 a miss. Any other value allows the whole table.
- R6: On a miss, whether because no entry fits or because the lane limit is passed first, the block reports `lanes_o`=0, `link_khz_o`=0 and `mode_ok_o`=0.
- R7: `done_o` is high for exactly one cycle. It rises k+1 clock edges after the edge that accepted the start, where k is the index at which the search decided. The outputs hold their values until the next `done_o`.
- R8: A start that arrives while a search is running is ignored. The running search ends with its own result, and no extra `done_o` follows.
- R9: An entry exactly equal to the mode clock does not fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse; latches the three request inputs when idle |
| mode_khz_i | input | 20 | Mode pixel clock in kHz |
| max_rate_i | input | 8 | Sink maximum link rate code |
| lane_cap_i | input | 8 | Sink lane-count capability byte |
| lanes_o | output | 3 | Chosen lane count, 0 on a miss |
| link_khz_o | output | 20 | Chosen link clock in kHz, 0 on a miss |
| mode_ok_o | output | 1 | Mode has a fitting configuration |
| done_o | output | 1 | One-cycle result strobe |

## Verification
A wrong scan index, or a wrong skip or limit decision, shows up at the ports in two ways. It changes the reported lanes or link clock, and it moves the `done_o` pulse by one or more cycles. The bench therefore checks both the values and the exact cycle of the strobe for every request. A corrupted latched request shows up as a result that belongs to a different request, which is most visible when a second start arrives during a long search. Every fault is visible within at most six cycles of the start.

// File: rtl/dpls_pkg.sv
package dpls_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } sel_state_e;

    typedef enum logic [1:0] {
        STEP_NEXT = 2'd0,
        STEP_HIT  = 2'd1,
        STEP_MISS = 2'd2
    } step_e;

    // Bandwidth of table index idx: lane group doubles every two entries,
    // odd entries use the high-rate per-lane figure.
    function automatic int unsigned entry_bw(input int unsigned idx,
                                             input int unsigned base_lo,
                                             input int unsigned base_hi);
        int unsigned per_lane;
        per_lane = (idx % 2 == 1) ? base_hi : base_lo;
        return (32'd1 << (idx >> 1)) * per_lane;
    endfunction

endpackage

// File: rtl/dpls_bw_rom.sv
module dpls_bw_rom #(
    parameter int unsigned N_ENTRY = 6,
    parameter int unsigned CLK_W   = 20,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned BASE_LO = 54000,
    parameter int unsigned BASE_HI = 90000
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [CLK_W-1:0] bw_o
);
    import dpls_pkg::*;

    logic [CLK_W-1:0] tbl [N_ENTRY];

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_entry
        assign tbl[g] = CLK_W'(entry_bw(g, BASE_LO, BASE_HI));
    end

    always_comb begin
        bw_o = '0;
        for (int i = 0; i < N_ENTRY; i++) begin
            if (idx_i == IDX_W'(i)) bw_o = tbl[i];
        end
    end
endmodule

// File: rtl/dpls_lane_cap.sv
module dpls_lane_cap #(
    parameter int unsigned N_ENTRY   = 6,
    parameter int unsigned IDX_W     = 3,
    parameter logic [7:0]  LANE_MASK = 8'h1F
) (
    input  logic [7:0]       lane_byte_i,
    output logic [IDX_W-1:0] last_idx_o
);
    logic [7:0] lanes_m;
    assign lanes_m = lane_byte_i & LANE_MASK;

    always_comb begin
        unique case (lanes_m)
            8'd1:    last_idx_o = IDX_W'(1);
            8'd2:    last_idx_o = IDX_W'(3);
            default: last_idx_o = IDX_W'(N_ENTRY - 1);
        endcase
    end
endmodule

// File: rtl/dpls_fit_eval.sv
module dpls_fit_eval #(
    parameter int unsigned N_ENTRY = 6,
    parameter int unsigned CLK_W   = 20,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [IDX_W-1:0] last_idx_i,
    input  logic             lo_only_i,
    input  logic [CLK_W-1:0] bw_i,
    input  logic [CLK_W-1:0] mode_khz_i,
    output dpls_pkg::step_e  step_o
);
    import dpls_pkg::*;

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_ENTRY - 1);

    logic at_top;
    assign at_top = (idx_i == TOP_IDX);

    always_comb begin
        if (idx_i > last_idx_i) begin
            step_o = STEP_MISS;
        end else if (lo_only_i && idx_i[0]) begin
            step_o = at_top ? STEP_MISS : STEP_NEXT;
        end else if (bw_i > mode_khz_i) begin
            step_o = STEP_HIT;
        end else begin
            step_o = at_top ? STEP_MISS : STEP_NEXT;
        end
    end
endmodule

// File: rtl/dp_link_select.sv
module dp_link_select #(
    parameter int unsigned N_ENTRY      = 6,
    parameter int unsigned CLK_W        = 20,
    parameter int unsigned BASE_LO_KHZ  = 54000,
    parameter int unsigned BASE_HI_KHZ  = 90000,
    parameter int unsigned LINK_LO_KHZ  = 162000,
    parameter int unsigned LINK_HI_KHZ  = 270000,
    parameter logic [7:0]  HI_RATE_CODE = 8'h0A,
    parameter logic [7:0]  LANE_MASK    = 8'h1F
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic [CLK_W-1:0]                    mode_khz_i,
    input  logic [7:0]                          max_rate_i,
    input  logic [7:0]                          lane_cap_i,
    output logic [((N_ENTRY-1)>>1):0]           lanes_o,
    output logic [CLK_W-1:0]                    link_khz_o,
    output logic                                mode_ok_o,
    output logic                                done_o
);
    import dpls_pkg::*;

    localparam int unsigned IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;
    localparam int unsigned LANE_W = ((N_ENTRY - 1) >> 1) + 1;

    sel_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CLK_W-1:0]  mode_q;
    logic              lo_q;
    logic [7:0]        lane_q;

    logic [CLK_W-1:0]  bw;
    logic [IDX_W-1:0]  last_idx;
    step_e             step;

    dpls_bw_rom #(
        .N_ENTRY(N_ENTRY), .CLK_W(CLK_W), .IDX_W(IDX_W),
        .BASE_LO(BASE_LO_KHZ), .BASE_HI(BASE_HI_KHZ)
    ) u_rom (
        .idx_i(idx_q),
        .bw_o (bw)
    );

    dpls_lane_cap #(
        .N_ENTRY(N_ENTRY), .IDX_W(IDX_W), .LANE_MASK(LANE_MASK)
    ) u_cap (
        .lane_byte_i(lane_q),
        .last_idx_o (last_idx)
    );

    dpls_fit_eval #(
        .N_ENTRY(N_ENTRY), .CLK_W(CLK_W), .IDX_W(IDX_W)
    ) u_eval (
        .idx_i     (idx_q),
        .last_idx_i(last_idx),
        .lo_only_i (lo_q),
        .bw_i      (bw),
        .mode_khz_i(mode_q),
        .step_o    (step)
    );

    // State register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            mode_q  <= '0;
            lo_q    <= 1'b1;
            lane_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q  <= mode_khz_i;
                        lo_q    <= (max_rate_i != HI_RATE_CODE);
                        lane_q  <= lane_cap_i;
                        idx_q   <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (step == STEP_NEXT) begin
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_o    <= '0;
            link_khz_o <= '0;
            mode_ok_o  <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state_q == ST_SCAN) begin
                if (step == STEP_HIT) begin
                    lanes_o    <= LANE_W'(1) << (idx_q >> 1);
                    link_khz_o <= (lo_q || !idx_q[0]) ? CLK_W'(LINK_LO_KHZ)
                                                      : CLK_W'(LINK_HI_KHZ);
                    mode_ok_o  <= 1'b1;
                    done_o     <= 1'b1;
                end else if (step == STEP_MISS) begin
                    lanes_o    <= '0;
                    link_khz_o <= '0;
                    mode_ok_o  <= 1'b0;
                    done_o     <= 1'b1;
                end
            end
        end
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(lanes_o) && $stable(link_khz_o) && $stable(mode_ok_o)));

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode_ok_o) |-> (lanes_o == '0 && link_khz_o == '0));

    // R2
    lanes_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_ok_o) |-> ($countones(lanes_o) == 1));

    // R3
    lo_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_ok_o && lo_q) |-> (link_khz_o == CLK_W'(LINK_LO_KHZ)));

    // R5
    one_lane_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_ok_o && ((lane_q & LANE_MASK) == 8'd1)) |-> (lanes_o == LANE_W'(1)));

    // R8
    busy_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=> ($stable(mode_q) && $stable(lane_q) && $stable(lo_q)));

endmodule

// File: tb/dp_link_select_tb.sv
module dp_link_select_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [19:0] mode_khz_i;
    logic [7:0]  max_rate_i;
    logic [7:0]  lane_cap_i;
    logic [2:0]  lanes_o;
    logic [19:0] link_khz_o;
    logic        mode_ok_o;
    logic        done_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dp_link_select u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mode_khz_i(mode_khz_i), .max_rate_i(max_rate_i), .lane_cap_i(lane_cap_i),
        .lanes_o(lanes_o), .link_khz_o(link_khz_o),
        .mode_ok_o(mode_ok_o), .done_o(done_o)
    );

    function automatic void ref_sel(input int mclk, input int rate, input int lbyte,
                                    output int lanes, output int link,
                                    output int ok, output int dec);
        int bwt [6] = '{54000, 90000, 108000, 180000, 216000, 360000};
        int lim;
        bit lo;
        int m;
        lo = (rate != 8'h0A);
        m = lbyte & 8'h1F;
        lim = (m == 1) ? 1 : (m == 2) ? 3 : 5;
        lanes = 0; link = 0; ok = 0; dec = 5;
        for (int i = 0; i < 6; i++) begin
            if (i > lim) begin dec = i; return; end
            if (lo && (i % 2 == 1)) continue;
            if (bwt[i] > mclk) begin
                dec = i; ok = 1;
                lanes = 1 << (i / 2);
                link = (lo || (i % 2 == 0)) ? 162000 : 270000;
                return;
            end
        end
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int mclk, input int rate, input int lbyte, input string tag);
        int el, el_link, el_ok, edec, c;
        ref_sel(mclk, rate, lbyte, el, el_link, el_ok, edec);
        @(negedge clk);
        mode_khz_i = 20'(mclk); max_rate_i = 8'(rate); lane_cap_i = 8'(lbyte);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        c = 0;
        while (c < 12) begin
            @(negedge clk);
            c++;
            if (done_o) break;
        end
        check({tag, " R7 latency"}, c, edec + 1);
        check({tag, " R2 lanes"}, int'(lanes_o), el);
        check({tag, " R4 link"}, int'(link_khz_o), el_link);
        check({tag, " R6 ok"}, int'(mode_ok_o), el_ok);
        @(negedge clk);
        check({tag, " R7 single"}, int'(done_o), 0);
        check({tag, " R7 hold"}, int'(lanes_o), el);
    endtask

    initial begin
        #4_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int el, el_link, el_ok, edec, c, extra;
        int lsel [4] = '{1, 2, 4, 3};
        void'($urandom(32'd20250611));
        rst_n = 1'b0; start_i = 1'b0;
        mode_khz_i = '0; max_rate_i = '0; lane_cap_i = '0;
        repeat (3) @(negedge clk);
        // R1
        check("R1 lanes", int'(lanes_o), 0);
        check("R1 link", int'(link_khz_o), 0);
        check("R1 ok", int'(mode_ok_o), 0);
        check("R1 done", int'(done_o), 0);
        rst_n = 1'b1;

        run(53999, 8'h06, 4, "R2 low");
        run(54000, 8'h06, 4, "R9 equal");
        run(60000, 8'h0A, 4, "R4 odd");
        run(100000, 8'h0A, 4, "R4 even");
        run(60000, 8'h14, 4, "R3 unknown");
        run(60000, 8'h06, 1, "R5 one");
        run(200000, 8'h0A, 2, "R5 two");
        run(150000, 8'h0A, 8'h84, "R5 mask");
        run(60000, 8'h0A, 8'h21, "R5 mask1");
        run(300000, 8'h0A, 3, "R5 other");
        run(360000, 8'h0A, 4, "R6 top");
        run(400000, 8'h06, 4, "R6 none");

        // R8: start during a long search
        ref_sel(300000, 8'h0A, 4, el, el_link, el_ok, edec);
        @(negedge clk);
        mode_khz_i = 20'd300000; max_rate_i = 8'h0A; lane_cap_i = 8'd4; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        mode_khz_i = 20'd1000; max_rate_i = 8'h06; lane_cap_i = 8'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        c = 2;
        while (c < 12) begin
            @(negedge clk);
            c++;
            if (done_o) break;
        end
        check("R8 latency", c, edec + 1);
        check("R8 lanes", int'(lanes_o), el);
        check("R8 link", int'(link_khz_o), el_link);
        extra = 0;
        repeat (10) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check("R8 no extra done", extra, 0);

        for (int k = 0; k < 150; k++) begin
            int mc, rc, lb;
            mc = int'($urandom_range(0, 400000));
            case ($urandom_range(0, 2))
                0: rc = 8'h0A;
                1: rc = 8'h06;
                default: rc = int'($urandom_range(0, 255));
            endcase
            lb = (int'($urandom_range(0, 7)) << 5) | lsel[$urandom_range(0, 3)];
            if ($urandom_range(0, 5) == 0) lb = int'($urandom_range(0, 255));
            run(mc, rc, lb, "R2 rand");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule